// File: doc/BRIEF.md
# Binary Field Montgomery Squarer

This block squares an element of GF(2^m) and returns the square scaled by x^-m and reduced modulo a caller-supplied polynomial, which is squaring in the Montgomery domain. The field size m is a parameter. It defaults to 163, and small sizes can be used for exhaustive testing.

The block works in two phases. First it spreads the operand bits into a double-width working register, so squaring needs no multiplier. It then runs m reduction iterations. Each one examines the lowest working bit and, if that bit is set, adds the modulus before shifting the register down one place.

The caller pulses `start_i` with the operand and the low coefficients of the modulus present. The result is held on `result_o` and marked by a one-cycle `done_o`. Entering and leaving the Montgomery domain is left to surrounding logic.

Top module: `gf2m_mont_sqr`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `done_o` is 0 and `result_o` is all zeros.
- R2: A `start_i` sampled high at a rising edge while the block is idle captures `operand_i` and `poly_i` at that edge and begins an operation.
- R3: Suppose `start_i` is accepted at edge k. Then `done_o` is 1 only in the cycle that follows edge k+m, and it is 0 in the cycles after edges k+m-1 and k+m+1.
- R4: The modulus is f = x^m + P, where P is the value of `poly_i` with bit j as the coefficient of x^j and bit 0 set. When `done_o` is 1, `result_o` holds the unique r of degree below m with r·x^m ≡ a² (mod f), where bit j of `operand_i` is the coefficient of x^j in a.
- R5: A `start_i` sampled high while an operation is in progress is ignored. The result and the timing of `done_o` stay those of the operation already running.
- R6: `result_o` keeps its value from one `done_o` pulse until the next completed operation, whatever `operand_i` and `poly_i` do in between.
- R7: Changes on `operand_i` or `poly_i` after the accepting edge have no effect on the running operation.
- R8: A zero operand yields a zero result under every modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a squaring |
| operand_i | input | M | Field element a, bit j is the coefficient of x^j |
| poly_i | input | M | Modulus below its leading term x^M, bit 0 must be 1 |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | M | a²·x^-M mod f, held until the next completion |

## Verification
The assertions assume that every accepted modulus has its constant term set. Only then does the added modulus clear the low bit before the shift. The stimulus therefore draws every modulus from odd values: all odd low parts for the small field, and forced-odd random values for the full field. The final check that the working register has no bits at or above position m depends on the same assumption. The bench never breaks it.

// File: rtl/gf2m_sqr_pkg.sv
package gf2m_sqr_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } sqr_phase_e;

endpackage

// File: rtl/gf2m_sqr_spread.sv
// Squaring over GF(2): coefficient j of a lands at position 2j, odd positions are zero.
module gf2m_sqr_spread #(
    parameter int M = 163
) (
    input  logic [M-1:0]   a_i,
    output logic [2*M-2:0] w_o
);
    for (genvar j = 0; j < M; j++) begin : g_even
        assign w_o[2*j] = a_i[j];
    end
    for (genvar j = 0; j < M-1; j++) begin : g_odd
        assign w_o[2*j+1] = 1'b0;
    end
endmodule

// File: rtl/gf2m_sqr_step.sv
// One reduction iteration: make the value divisible by x, then divide by x.
module gf2m_sqr_step #(
    parameter int M = 163
) (
    input  logic [2*M-2:0] w_i,
    input  logic [M-1:0]   poly_i,
    output logic [2*M-2:0] w_o
);
    logic [2*M-2:0] sum;

    always_comb begin
        sum = w_i;
        if (w_i[0]) begin
            sum[M-1:0] = w_i[M-1:0] ^ poly_i;
            sum[M]     = ~w_i[M];
        end
        w_o = sum >> 1;
    end
endmodule

// File: rtl/gf2m_mont_sqr.sv
module gf2m_mont_sqr
    import gf2m_sqr_pkg::*;
#(
    parameter int M = 163
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [M-1:0] operand_i,
    input  logic [M-1:0] poly_i,
    output logic         done_o,
    output logic [M-1:0] result_o
);
    localparam int W  = 2*M - 1;
    localparam int CW = $clog2(M + 1);
    localparam logic [CW-1:0] LAST = CW'(M - 1);

    typedef struct packed {
        sqr_phase_e    phase;
        logic [CW-1:0] cnt;
        logic [W-1:0]  work;
        logic [M-1:0]  poly;
        logic [M-1:0]  res;
        logic          done;
    } sqr_state_t;

    sqr_state_t st_d, st_q;
    logic [W-1:0] spread_w;
    logic [W-1:0] step_w;

    gf2m_sqr_spread #(.M(M)) u_spread (
        .a_i (operand_i),
        .w_o (spread_w)
    );

    gf2m_sqr_step #(.M(M)) u_step (
        .w_i    (st_q.work),
        .poly_i (st_q.poly),
        .w_o    (step_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_RUN;
                    st_d.cnt   = '0;
                    st_d.work  = spread_w;
                    st_d.poly  = poly_i;
                end
            end
            default: begin
                st_d.work = step_w;
                st_d.cnt  = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST) begin
                    st_d.phase = PH_IDLE;
                    st_d.res   = step_w[M-1:0];
                    st_d.done  = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o   = st_q.done;
    assign result_o = st_q.res;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!done_o && result_o == '0));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_IDLE && start_i) |=> (st_q.phase == PH_RUN && st_q.cnt == '0));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    done_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN && st_q.cnt == LAST) |=> done_o);

    // R4
    reduced_degree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (st_q.work[W-1:M] == '0));

    // R4
    odd_modulus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN) |-> st_q.poly[0]);

    // R5 R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN && st_q.cnt != LAST) |=> (st_q.phase == PH_RUN && $stable(st_q.poly)));

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
endmodule

// File: tb/gf2m_mont_sqr_bench.sv
`timescale 1ns/1ps
module gf2m_mont_sqr_bench;
    localparam int MB = 163;
    localparam int MS = 5;
    localparam int XW = 2*MB + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          s_start, b_start;
    logic [MS-1:0] s_op, s_poly, s_res;
    logic [MB-1:0] b_op, b_poly, b_res;
    logic          s_done, b_done;

    int checks = 0;
    int fails  = 0;

    gf2m_mont_sqr #(.M(MB)) u_gf2m_mont_sqr (
        .clk(clk), .rst_n(rst_n), .start_i(b_start), .operand_i(b_op),
        .poly_i(b_poly), .done_o(b_done), .result_o(b_res));

    gf2m_mont_sqr #(.M(MS)) u_gf2m_mont_sqr_small (
        .clk(clk), .rst_n(rst_n), .start_i(s_start), .operand_i(s_op),
        .poly_i(s_poly), .done_o(s_done), .result_o(s_res));

    // a*b mod f by shift-and-add from the top, f includes x^m
    function automatic logic [XW-1:0] mulmod(input logic [XW-1:0] a, input logic [XW-1:0] b,
                                            input logic [XW-1:0] f, input int m);
        logic [XW-1:0] acc = '0;
        for (int i = m-1; i >= 0; i--) begin
            acc = acc << 1;
            if (acc[m]) acc = acc ^ f;
            if (b[i]) acc = acc ^ a;
        end
        return acc;
    endfunction

    // r*x^m mod f
    function automatic logic [XW-1:0] times_xm(input logic [XW-1:0] r, input logic [XW-1:0] f,
                                              input int m);
        logic [XW-1:0] acc = r;
        for (int i = 0; i < m; i++) begin
            acc = acc << 1;
            if (acc[m]) acc = acc ^ f;
        end
        return acc;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [XW-1:0] act,
                         input logic [XW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_result(input int m, input logic [XW-1:0] a, input logic [XW-1:0] p,
                                input logic [XW-1:0] r, input string tag);
        logic [XW-1:0] f, lhs, rhs;
        f = p;
        f[m] = 1'b1;
        lhs = times_xm(r, f, m);
        rhs = mulmod(a, a, f, m);
        check((lhs == rhs) && ((r >> m) == '0), tag, lhs, rhs);
        if (a == '0) check(r == '0, "R8 zero operand", r, '0);
    endtask

    task automatic run_small(input logic [MS-1:0] a, input logic [MS-1:0] p, input bit disturb);
        s_op = a; s_poly = p; s_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s_start = 1'b0;
        for (int j = 1; j <= MS; j++) begin
            if (disturb && j == 1) begin s_start = 1'b1; s_op = ~a; s_poly = p ^ 5'b10110; end
            if (disturb && j == 2) s_start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            if (j == MS-1) check(s_done == 1'b0, "R3 done early", XW'(s_done), 0);
        end
        check(s_done == 1'b1, "R3 done at m", XW'(s_done), 1);
        check_result(MS, XW'(a), XW'(p), XW'(s_res), disturb ? "R5 R7 small result" : "R4 small result");
        @(posedge clk);
        @(negedge clk);
        check(s_done == 1'b0, "R3 done late", XW'(s_done), 0);
    endtask

    task automatic run_big(input logic [MB-1:0] a, input logic [MB-1:0] p, input bit disturb);
        b_op = a; b_poly = p; b_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        b_start = 1'b0;
        for (int j = 1; j <= MB; j++) begin
            if (disturb && j == 1) begin b_start = 1'b1; b_op = ~a; b_poly = {p[MB-1:1] ^ 162'h5, 1'b1}; end
            if (disturb && j == 2) b_start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            if (j == MB-1) check(b_done == 1'b0, "R3 big done early", XW'(b_done), 0);
        end
        check(b_done == 1'b1, "R3 big done at m", XW'(b_done), 1);
        check_result(MB, XW'(a), XW'(p), XW'(b_res), disturb ? "R5 R7 big result" : "R4 big result");
        @(posedge clk);
        @(negedge clk);
        check(b_done == 1'b0, "R3 big done late", XW'(b_done), 0);
    endtask

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [MS-1:0] held;
        logic [MB-1:0] dflt, ba, bp;
        s_start = 1'b0; b_start = 1'b0;
        s_op = '0; s_poly = 5'b00101; b_op = '0; b_poly = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check(!s_done && s_res == '0 && !b_done && b_res == '0, "R1 in reset",
              XW'(s_res), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R1 first cycle after release
        check(!s_done && s_res == '0, "R1 after release", XW'(s_res), 0);

        // R2 R4 R8: every operand under every odd modulus of the small field
        for (int p = 1; p < 32; p += 2) begin
            for (int a = 0; a < 32; a++) begin
                run_small(MS'(a), MS'(p), 1'b0);
            end
        end

        // R5 R7: start and input changes while busy
        for (int a = 0; a < 32; a += 3) run_small(MS'(a), 5'b01101, 1'b1);

        // R6: inputs wiggle with no start, result must hold
        held = s_res;
        for (int k = 0; k < 4; k++) begin
            s_op = MS'(k * 7); s_poly = MS'(k * 5);
            @(posedge clk);
            @(negedge clk);
            check(s_res == held && !s_done, "R6 result held", XW'(s_res), XW'(held));
        end

        // default field: x^163 + x^7 + x^6 + x^3 + 1
        dflt = {155'd0, 8'hC9};
        run_big('0, dflt, 1'b0);
        run_big(163'd1, dflt, 1'b0);
        run_big({MB{1'b1}}, dflt, 1'b0);
        for (int n = 0; n < 14; n++) begin
            ba = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            run_big(ba, dflt, n % 4 == 1);
        end
        for (int n = 0; n < 6; n++) begin
            ba = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            bp = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            bp[0] = 1'b1;
            run_big(ba, bp, n == 2);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule